// File: doc/BRIEF.md
# Bit-Band Alias Remapper

This block sits between a processor's data port and the downstream memory bus. It watches every request for two alias windows. In each window, every 32-bit word stands for a single bit of a smaller bit-band window. An aliased read comes back as that one bit, zero-extended into bit 0 of the read data. An aliased write becomes a locked read-modify-write of the target word, and only the addressed bit changes. Every other request goes to the downstream bus untouched. This covers instruction fetches, direct accesses inside the bit-band windows, and all other addresses.

Both sides use a valid/ready request channel with 32-bit address and data, and a one-cycle response pulse that is always accepted. The block handles one request at a time. It takes a new request only when it is idle. While a read-modify-write is in flight, a lock output tells the downstream interconnect to keep other masters away from the target word.

Top module: `bitband_remap`

## Requirements
- R1: A data read from the low alias window 0x22000000–0x23FFFFFF issues one downstream read and returns the addressed bit in bit 0, with bits 31:1 zero. For alias offset `o = addr - 0x22000000`, the downstream word address is `0x20000000 + (o[24:7] << 2)` and the bit index is `o[6:2]`.
- R2: A data read from the high alias window 0x42000000–0x43FFFFFF behaves as in R1, with alias base 0x42000000 and bit-band base 0x40000000.
- R3: A data write to either alias window runs one downstream read and then one downstream write to the same word. The written word equals the read word with only the indexed bit replaced by write-data bit 0. Write-data bits 31:1 are ignored, and the upstream response data is zero.
- R4: `dn_lock` is high when the read of an alias write is accepted and when its write is accepted. It is low at every request of a non-aliased access or an alias read, and whenever the block is idle.
- R5: `up_req_ready` is high only in the idle state. It stays low from the cycle after acceptance until the response has been delivered.
- R6: A request with `up_req_fetch` high is never remapped, even inside an alias window. It is forwarded with its own address.
- R7: Any data access outside both alias windows is forwarded unchanged: same address, same direction, same write data. This includes the bit-band windows themselves and the addresses next to each alias window's edges. Read data comes back unmodified.
- R8: After reset, `up_req_ready` is high, and `dn_req_valid`, `dn_lock` and `up_rsp_valid` are low.
- R9: Every accepted request produces exactly one single-cycle `up_rsp_valid` pulse. A downstream request is held stable until it is accepted, and a write is answered with zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_req_valid | input | 1 | Upstream request valid |
| up_req_ready | output | 1 | Upstream request accepted (idle only) |
| up_req_addr | input | 32 | Upstream byte address |
| up_req_write | input | 1 | 1 = write, 0 = read |
| up_req_wdata | input | 32 | Upstream write data |
| up_req_fetch | input | 1 | 1 = instruction fetch (never remapped) |
| up_rsp_valid | output | 1 | Upstream response pulse |
| up_rsp_rdata | output | 32 | Upstream read data (zero for writes) |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream request accepted |
| dn_req_addr | output | 32 | Downstream byte address |
| dn_req_write | output | 1 | Downstream direction |
| dn_req_wdata | output | 32 | Downstream write data |
| dn_lock | output | 1 | Atomic lock during alias read-modify-write |
| dn_rsp_valid | input | 1 | Downstream response pulse |
| dn_rsp_rdata | input | 32 | Downstream read data |

## Verification
The in-line properties check, on every cycle, the handshake rules of the sequencer. Upstream ready and a downstream request are never high together. Each response is a single pulse followed by idle. A stalled downstream request keeps its address. The lock is low when idle, covers the write of each alias read-modify-write, and drops only after a downstream response. An alias read also returns nothing above bit 0. The bench scenarios are the only place that shows the data paths against a reference memory. Those paths are the alias-to-word address arithmetic at each window edge, that only the one bit changes, that fetches and neighbouring addresses are forwarded unchanged, and that write-data bits 31:1 are ignored.

// File: rtl/bb_remap_pkg.sv
// Package: shared sizes, window bases and sequencer states for the
// bit-band alias remapper. Assumes a byte-addressed bus whose data width
// is a power of two of at least 16 bits.
package bb_remap_pkg;
    parameter int ADDR_W    = 32;
    parameter int DATA_W    = 32;
    parameter int BB_SPAN_W = 20;              // bit-band window = 2**BB_SPAN_W bytes
    parameter int NUM_WIN   = 2;

    localparam int BIT_IDX_W    = $clog2(DATA_W);          // bit within a bus word
    localparam int LANE_W       = $clog2(DATA_W / 8);      // byte lanes per word
    localparam int ALIAS_SPAN_W = BB_SPAN_W + 3 + LANE_W;  // one alias word per bit
    localparam int WORD_SEL_W   = ALIAS_SPAN_W - BIT_IDX_W - LANE_W;

    parameter logic [ADDR_W-1:0] ALIAS_BASE [NUM_WIN] = '{32'h2200_0000, 32'h4200_0000};
    parameter logic [ADDR_W-1:0] BAND_BASE  [NUM_WIN] = '{32'h2000_0000, 32'h4000_0000};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_WR_WAIT,
        ST_RESP
    } seq_state_e;
endpackage

// File: rtl/bb_alias_decode.sv
// Module: bb_alias_decode
// Decodes an upstream address against every alias window. On a hit by a
// data access it gives the downstream word address inside the matching
// bit-band window and the bit index within that word.
// Assumes alias windows are aligned to their own size and do not overlap.
module bb_alias_decode
    import bb_remap_pkg::*;
(
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 fetch,
    output logic                 hit,
    output logic [ADDR_W-1:0]    word_addr,
    output logic [BIT_IDX_W-1:0] bit_idx
);
    logic [NUM_WIN-1:0] win_hit;
    logic [ADDR_W-1:0]  win_word [NUM_WIN];
    logic [ALIAS_SPAN_W-1:0] offset;

    assign offset = addr[ALIAS_SPAN_W-1:0];

    // One comparator and word-address adder per window.
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        assign win_hit[w]  = !fetch &&
            (addr[ADDR_W-1:ALIAS_SPAN_W] == ALIAS_BASE[w][ADDR_W-1:ALIAS_SPAN_W]);
        assign win_word[w] = BAND_BASE[w] +
            ADDR_W'({offset[ALIAS_SPAN_W-1:BIT_IDX_W+LANE_W], {LANE_W{1'b0}}});
    end

    // Select the hit window's word address; bit index is window independent.
    always_comb begin
        hit       = |win_hit;
        word_addr = addr;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (win_hit[w]) word_addr = win_word[w];
        end
        bit_idx = offset[BIT_IDX_W+LANE_W-1:LANE_W];
    end

    // p_onehot_win_r7: windows must never overlap
    always_comb begin
        assert ($onehot0(win_hit)) else $error("p_onehot_win_r7: overlapping windows");
    end
endmodule

// File: rtl/bb_rmw_seq.sv
// Module: bb_rmw_seq
// Single-outstanding sequencer. A non-aliased access becomes one
// downstream transfer. An alias read is one downstream read reduced to one
// bit. An alias write is a locked read followed by a write that changes
// one bit. Assumes downstream responses arrive no earlier than the cycle
// after request acceptance, and that upstream responses are never stalled.
module bb_rmw_seq
    import bb_remap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 up_req_valid,
    output logic                 up_req_ready,
    input  logic [ADDR_W-1:0]    up_req_addr,
    input  logic                 up_req_write,
    input  logic [DATA_W-1:0]    up_req_wdata,
    output logic                 up_rsp_valid,
    output logic [DATA_W-1:0]    up_rsp_rdata,
    input  logic                 dec_hit,
    input  logic [ADDR_W-1:0]    dec_word_addr,
    input  logic [BIT_IDX_W-1:0] dec_bit_idx,
    output logic                 dn_req_valid,
    input  logic                 dn_req_ready,
    output logic [ADDR_W-1:0]    dn_req_addr,
    output logic                 dn_req_write,
    output logic [DATA_W-1:0]    dn_req_wdata,
    output logic                 dn_lock,
    input  logic                 dn_rsp_valid,
    input  logic [DATA_W-1:0]    dn_rsp_rdata
);
    seq_state_e           state_q;
    logic [ADDR_W-1:0]    tgt_q;
    logic                 wr_q;
    logic                 alias_q;
    logic [BIT_IDX_W-1:0] bit_q;
    logic                 newbit_q;
    logic [DATA_W-1:0]    wdata_q;
    logic [DATA_W-1:0]    rsp_q;
    logic [DATA_W-1:0]    merged;

    // Replace the addressed bit of the word just read.
    always_comb begin
        merged         = dn_rsp_rdata;
        merged[bit_q]  = newbit_q;
    end

    // State and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            tgt_q    <= '0;
            wr_q     <= 1'b0;
            alias_q  <= 1'b0;
            bit_q    <= '0;
            newbit_q <= 1'b0;
            wdata_q  <= '0;
            rsp_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (up_req_valid) begin
                    tgt_q    <= dec_hit ? dec_word_addr : up_req_addr;
                    wr_q     <= up_req_write;
                    alias_q  <= dec_hit;
                    bit_q    <= dec_bit_idx;
                    newbit_q <= up_req_wdata[0];
                    wdata_q  <= up_req_wdata;
                    state_q  <= (up_req_write && !dec_hit) ? ST_WR_REQ : ST_RD_REQ;
                end
                ST_RD_REQ: if (dn_req_ready) state_q <= ST_RD_WAIT;
                ST_RD_WAIT: if (dn_rsp_valid) begin
                    if (alias_q && wr_q) begin
                        wdata_q <= merged;
                        state_q <= ST_WR_REQ;
                    end else begin
                        rsp_q   <= alias_q ? DATA_W'(dn_rsp_rdata[bit_q]) : dn_rsp_rdata;
                        state_q <= ST_RESP;
                    end
                end
                ST_WR_REQ: if (dn_req_ready) state_q <= ST_WR_WAIT;
                ST_WR_WAIT: if (dn_rsp_valid) begin
                    rsp_q   <= '0;
                    state_q <= ST_RESP;
                end
                ST_RESP: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Port decode of the current state.
    always_comb begin
        up_req_ready = (state_q == ST_IDLE);
        up_rsp_valid = (state_q == ST_RESP);
        up_rsp_rdata = rsp_q;
        dn_req_valid = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
        dn_req_write = (state_q == ST_WR_REQ);
        dn_req_addr  = tgt_q;
        dn_req_wdata = wdata_q;
        dn_lock      = alias_q && wr_q &&
                       (state_q inside {ST_RD_REQ, ST_RD_WAIT, ST_WR_REQ, ST_WR_WAIT});
    end

    // p_busy_not_ready_r5: never take a request while a transfer is pending
    p_busy_not_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_valid |-> !up_req_ready);

    // p_lock_idle_r4: lock is released whenever idle
    p_lock_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        up_req_ready |-> !dn_lock);

    // p_lock_release_r4: lock drops only after a downstream response
    p_lock_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dn_lock) |-> $past(dn_rsp_valid));

    // p_lock_write_r3: the write of an alias update is always locked
    p_lock_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_valid && dn_req_write && alias_q) |-> dn_lock);

    // p_req_hold_r9: a stalled downstream request keeps its address
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_valid && !dn_req_ready) |=> (dn_req_valid && $stable(dn_req_addr)));

    // p_rsp_pulse_r9: a response lasts one cycle and is followed by idle
    p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        up_rsp_valid |=> (!up_rsp_valid && up_req_ready));

    // p_alias_rdata_r1: alias read data carries nothing above bit 0
    p_alias_rdata_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (up_rsp_valid && alias_q && !wr_q) |-> (up_rsp_rdata[DATA_W-1:1] == '0));
endmodule

// File: rtl/bitband_remap.sv
// Module: bitband_remap (top)
// Remaps data accesses in the alias windows to single-bit operations on the
// matching bit-band windows; all other traffic is forwarded unchanged.
// Assumes one upstream master and a downstream bus that honours dn_lock.
module bitband_remap
    import bb_remap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_req_valid,
    output logic              up_req_ready,
    input  logic [ADDR_W-1:0] up_req_addr,
    input  logic              up_req_write,
    input  logic [DATA_W-1:0] up_req_wdata,
    input  logic              up_req_fetch,
    output logic              up_rsp_valid,
    output logic [DATA_W-1:0] up_rsp_rdata,
    output logic              dn_req_valid,
    input  logic              dn_req_ready,
    output logic [ADDR_W-1:0] dn_req_addr,
    output logic              dn_req_write,
    output logic [DATA_W-1:0] dn_req_wdata,
    output logic              dn_lock,
    input  logic              dn_rsp_valid,
    input  logic [DATA_W-1:0] dn_rsp_rdata
);
    logic                 dec_hit;
    logic [ADDR_W-1:0]    dec_word_addr;
    logic [BIT_IDX_W-1:0] dec_bit_idx;

    // Address decode of the incoming request.
    bb_alias_decode u_decode (
        .addr      (up_req_addr),
        .fetch     (up_req_fetch),
        .hit       (dec_hit),
        .word_addr (dec_word_addr),
        .bit_idx   (dec_bit_idx)
    );

    // Transfer and read-modify-write sequencing.
    bb_rmw_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .up_req_valid  (up_req_valid),
        .up_req_ready  (up_req_ready),
        .up_req_addr   (up_req_addr),
        .up_req_write  (up_req_write),
        .up_req_wdata  (up_req_wdata),
        .up_rsp_valid  (up_rsp_valid),
        .up_rsp_rdata  (up_rsp_rdata),
        .dec_hit       (dec_hit),
        .dec_word_addr (dec_word_addr),
        .dec_bit_idx   (dec_bit_idx),
        .dn_req_valid  (dn_req_valid),
        .dn_req_ready  (dn_req_ready),
        .dn_req_addr   (dn_req_addr),
        .dn_req_write  (dn_req_write),
        .dn_req_wdata  (dn_req_wdata),
        .dn_lock       (dn_lock),
        .dn_rsp_valid  (dn_rsp_valid),
        .dn_rsp_rdata  (dn_rsp_rdata)
    );
endmodule

// File: tb/sim_bitband_remap.sv
// Bench: drives directed edge cases and seeded random traffic, models the
// downstream memory, and compares every result against a reference memory.
module sim_bitband_remap;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_req_valid = 1'b0;
    logic        up_req_ready;
    logic [31:0] up_req_addr = '0;
    logic        up_req_write = 1'b0;
    logic [31:0] up_req_wdata = '0;
    logic        up_req_fetch = 1'b0;
    logic        up_rsp_valid;
    logic [31:0] up_rsp_rdata;
    logic        dn_req_valid;
    logic        dn_req_ready = 1'b0;
    logic [31:0] dn_req_addr;
    logic        dn_req_write;
    logic [31:0] dn_req_wdata;
    logic        dn_lock;
    logic        dn_rsp_valid = 1'b0;
    logic [31:0] dn_rsp_rdata = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [31:0] dmem    [logic [31:0]];
    logic [31:0] ref_mem [logic [31:0]];

    // downstream monitor
    int          n_rd, n_wr;
    logic [31:0] rd_addr, wr_addr, wr_data;
    logic        lock_rd, lock_wr, lock_other;
    int          pend = 0;
    logic [31:0] pend_data = '0;

    bitband_remap u0 (.*);

    always #5 clk = ~clk;

    function automatic logic [31:0] init_word(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h5A3C_96E1;
    endfunction

    function automatic logic [31:0] dm_get(input logic [31:0] a);
        return dmem.exists(a) ? dmem[a] : init_word(a);
    endfunction

    function automatic logic [31:0] ref_get(input logic [31:0] a);
        return ref_mem.exists(a) ? ref_mem[a] : init_word(a);
    endfunction

    // Alias mapping from the requirement text (range form).
    function automatic logic alias_map(input logic [31:0] a, input logic f,
                                       output logic [31:0] word, output int bitn);
        logic [31:0] abase, bbase, off;
        word = a; bitn = 0;
        if (f) return 1'b0;
        if (a >= 32'h2200_0000 && a <= 32'h23FF_FFFF) begin
            abase = 32'h2200_0000; bbase = 32'h2000_0000;
        end else if (a >= 32'h4200_0000 && a <= 32'h43FF_FFFF) begin
            abase = 32'h4200_0000; bbase = 32'h4000_0000;
        end else return 1'b0;
        off  = a - abase;
        word = bbase + ((off / 128) * 4);
        bitn = int'((off / 4) % 32);
        return 1'b1;
    endfunction

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Downstream memory: random ready, 1..3 cycle response latency.
    always @(negedge clk) begin
        dn_rsp_valid <= 1'b0;
        if (pend != 0) begin
            pend = pend - 1;
            if (pend == 0) begin
                dn_rsp_valid <= 1'b1;
                dn_rsp_rdata <= pend_data;
            end
        end
        dn_req_ready <= 1'b0;
        if (pend == 0 && rst_n) begin
            logic r;
            r = ($urandom_range(0, 1) == 1);
            dn_req_ready <= r;
            if (r && dn_req_valid) begin
                if (dn_req_write) begin
                    n_wr++; wr_addr = dn_req_addr; wr_data = dn_req_wdata;
                    lock_wr = dn_lock;
                    dmem[dn_req_addr] = dn_req_wdata;
                    pend_data = '0;
                end else begin
                    n_rd++; rd_addr = dn_req_addr; lock_rd = dn_lock;
                    pend_data = dm_get(dn_req_addr);
                end
                pend = 1 + $urandom_range(0, 2);
            end
        end
    end

    // Watchdog: a hung run ends as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles >= 150000) begin
            errors++; checks++;
            $display("FAIL R9: watchdog actual=%0d expected=<150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic access(input logic [31:0] a, input logic w,
                          input logic [31:0] d, input logic f);
        logic [31:0] word, exp_rd, got, nw;
        int          bitn, leak;
        logic        is_alias;
        string       rtag;
        is_alias = alias_map(a, f, word, bitn);
        rtag = f ? "R6" : (is_alias ? ((a < 32'h4000_0000) ? "R1" : "R2") : "R7");
        n_rd = 0; n_wr = 0; lock_rd = 0; lock_wr = 0; leak = 0;
        @(negedge clk);
        up_req_valid = 1'b1; up_req_addr = a; up_req_write = w;
        up_req_wdata = d; up_req_fetch = f;
        while (!up_req_ready) @(negedge clk);
        @(negedge clk);
        up_req_valid = 1'b0;
        while (!up_rsp_valid) begin
            if (up_req_ready) leak++;
            @(negedge clk);
        end
        got = up_rsp_rdata;
        check(leak == 0, "R5 ready low while busy", leak, 0);
        if (is_alias && w) begin
            nw = ref_get(word);
            nw[bitn] = d[0];
            ref_mem[word] = nw;
            check(n_rd == 1 && n_wr == 1, "R3 one read one write", n_rd * 16 + n_wr, 17);
            check(rd_addr == word && wr_addr == word, "R3 target word", wr_addr, word);
            check(dm_get(word) == nw, "R3 single bit changed", dm_get(word), nw);
            check(got == 0, "R9 write response zero", got, 0);
            check(lock_rd && lock_wr, "R4 lock over read and write", {lock_rd, lock_wr}, 2'b11);
        end else if (is_alias) begin
            exp_rd = {31'b0, ref_get(word)[bitn]};
            check(n_rd == 1 && n_wr == 0, {rtag, " one read"}, n_rd, 1);
            check(rd_addr == word, {rtag, " word address"}, rd_addr, word);
            check(got == exp_rd, {rtag, " alias bit"}, got, exp_rd);
            check(!lock_rd, "R4 no lock on alias read", lock_rd, 0);
        end else if (w) begin
            ref_mem[a] = d;
            check(n_wr == 1 && n_rd == 0, {rtag, " one write"}, n_wr, 1);
            check(wr_addr == a && wr_data == d, {rtag, " write unchanged"}, wr_data, d);
            check(dm_get(a) == ref_get(a), {rtag, " memory"}, dm_get(a), ref_get(a));
            check(!lock_wr, "R4 no lock on passthrough", lock_wr, 0);
        end else begin
            exp_rd = ref_get(a);
            check(n_rd == 1 && n_wr == 0, {rtag, " one read"}, n_rd, 1);
            check(rd_addr == a, {rtag, " address unchanged"}, rd_addr, a);
            check(got == exp_rd, {rtag, " read data"}, got, exp_rd);
            check(!lock_rd, "R4 no lock on passthrough", lock_rd, 0);
        end
        @(negedge clk);
        check(!up_rsp_valid && up_req_ready, "R9 single response pulse", up_rsp_valid, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R8: reset state
        check(up_req_ready == 1'b1, "R8 ready after reset", up_req_ready, 1);
        check(dn_req_valid == 1'b0, "R8 no downstream request", dn_req_valid, 0);
        check(dn_lock == 1'b0, "R8 lock low", dn_lock, 0);
        check(up_rsp_valid == 1'b0, "R8 no response", up_rsp_valid, 0);
        rst_n = 1'b1;

        // R1/R2: window edges of both alias windows
        access(32'h2200_0000, 0, 0, 0);
        access(32'h23FF_FFFC, 0, 0, 0);
        access(32'h4200_0000, 0, 0, 0);
        access(32'h43FF_FFFC, 0, 0, 0);
        access(32'h2200_00E4, 0, 0, 0);
        // R3: set and clear with noisy upper write-data bits
        access(32'h2200_0000, 1, 32'hFFFF_FFFE, 0);
        access(32'h2200_0000, 0, 0, 0);
        access(32'h23FF_FFFC, 1, 32'h0000_0001, 0);
        access(32'h23FF_FFFC, 0, 0, 0);
        access(32'h4200_0044, 1, 32'h8000_0001, 0);
        access(32'h4000_0000, 0, 0, 0);
        access(32'h43FF_FFFC, 1, 32'h7FFF_FFFE, 0);
        // R6: fetches to alias addresses are forwarded
        access(32'h2200_0010, 0, 0, 1);
        access(32'h43FF_FFF0, 0, 0, 1);
        // R7: neighbours of the windows and the bit-band windows themselves
        access(32'h21FF_FFFC, 0, 0, 0);
        access(32'h2400_0000, 1, 32'hDEAD_BEEF, 0);
        access(32'h2400_0000, 0, 0, 0);
        access(32'h41FF_FFFC, 0, 0, 0);
        access(32'h4400_0000, 0, 0, 0);
        access(32'h2000_0000, 1, 32'h1234_5678, 0);
        access(32'h2200_0000, 0, 0, 0);
        access(32'h400F_FFFC, 0, 0, 0);

        // Seeded random mix over overlapping alias and direct words
        for (int i = 0; i < 400; i++) begin
            int          kind;
            logic [31:0] a, d;
            logic        w, f;
            kind = $urandom_range(0, 4);
            w    = ($urandom_range(0, 1) == 1);
            d    = $urandom();
            f    = ($urandom_range(0, 7) == 0);
            case (kind)
                0: a = 32'h2200_0000 + ($urandom_range(0, 2047) * 4);
                1: a = 32'h4200_0000 + ($urandom_range(0, 2047) * 4);
                2: a = 32'h2000_0000 + ($urandom_range(0, 63) * 4);
                3: a = 32'h4000_0000 + ($urandom_range(0, 63) * 4);
                default: a = {$urandom()} & 32'hFFFF_FFFC;
            endcase
            if (f) w = 1'b0;
            access(a, w, d, f);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule